// File: doc/BRIEF.md
# Multiplexed segment LCD waveform sequencer

This block produces the digital pin control for a multiplexed segment LCD panel. Software loads segment bits through a byte-wide write port into a bank of display registers. Each common owns a fixed group of consecutive bytes. At every frame boundary the whole bank is copied into a shadow latch. The sequencer then walks through the used commons. Each common gets two half-phases of opposite polarity, so that no pixel sees a net DC voltage. For each half-phase the block emits a 2-bit level code for every common and segment pin, a per-pin tristate enable and one enable for the intermediate-level buffers.

The bias input selects either one or two intermediate levels. The duty input selects between one and `NUM_COM` commons. A 3-bit drive-time code limits how long the intermediate-level buffers stay on in each half-phase. When that time runs out, every pin goes tristate. The slot tick advances the sequencer by one half-phase. Nothing is driven until the supply-ready input is high. The analog switches and the supply regulation sit outside this block.

Top module: `lcd_mux_seq`

## Requirements
- R1: While `supply_ok_i` is low, every common and segment pin has tristate enable 1 and level 0, `buf_en_o` is 0, and slot ticks are ignored. On the first clock edge with `supply_ok_i` high, a frame starts on common 0, first half-phase.
- R2: Each clock edge with `slot_tick_i` high advances one half-phase. A common gets a first half and then a second half. Commons are visited from 0 up to `duty_i`, where `duty_i` holds the number of commons minus one. After the second half of the last common the sequence returns to common 0 and a new frame begins.
- R3: Common c takes its segment bits from bytes c*GROUP_BYTES to c*GROUP_BYTES+GROUP_BYTES-1. Segment s uses byte offset s/8 and bit s%8 within that group, and a bit value of 1 means lit.
- R4: The display bank is copied to the shadow latch on the clock edge that starts each frame. A write made during a frame does not change the output until the following frame.
- R5: Level codes 0 to 3 select V0 < V1 < V2 < V3, and pin c uses bits [2c+1:2c] of its level port. With 1/3 bias (`bias_third_i`=1), the addressed common is driven at 3 and then 0. The other used commons are driven at 1 and then 2. Commons above `duty_i` are tristate with level 0.
- R6: With 1/3 bias, a lit segment is driven at 0 and then 3, and a dark segment at 2 and then 1.
- R7: With 1/2 bias (`bias_third_i`=0), the single middle level is code 1. Non-addressed used commons and dark segments sit at 1 in both halves. Addressed commons and lit segments behave as in R5 and R6.
- R8: With `duty_i`=0 (static drive), common 0 is driven at 3 and then 0. Lit segments are driven at 0 and then 3, and dark segments at 3 and then 0. `buf_en_o` stays 0 and the pins are never tristated, whatever the drive code.
- R9: With more than one common, at each half-phase boundary `buf_en_o` rises and the pins are driven for 2^(n+1) clock cycles, where n is `drive_code_i`. After that, all pins go tristate and `buf_en_o` falls until the next boundary. Code 7 keeps the pins driven for the whole half-phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Display byte write strobe |
| wr_addr_i | input | ADDR_W | Display byte index |
| wr_data_i | input | 8 | Display byte value |
| duty_i | input | COM_W | Number of commons minus one |
| bias_third_i | input | 1 | 1: 1/3 bias, 0: 1/2 bias |
| drive_code_i | input | 3 | Buffer drive-time code |
| supply_ok_i | input | 1 | Panel supply has reached its target |
| slot_tick_i | input | 1 | Half-phase advance strobe |
| com_lvl_o | output | 2*NUM_COM | Level code per common pin |
| com_hiz_o | output | NUM_COM | Tristate enable per common pin |
| seg_lvl_o | output | 2*NUM_SEG | Level code per segment pin |
| seg_hiz_o | output | NUM_SEG | Tristate enable per segment pin |
| buf_en_o | output | 1 | Intermediate-level buffer enable |

## Verification
The bench builds the block with GROUP_BYTES=2 and NUM_COM=4, which gives 16 segment pins and an 8-byte bank. With these sizes every segment pin can be compared in a single vector, and the byte boundary inside a group is exercised. Four commons allow duties of one to four. This covers the frame wrap at every duty, the rule that unused commons go tristate, and the static case.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam logic [1:0] LV0 = 2'd0;
  localparam logic [1:0] LV1 = 2'd1;
  localparam logic [1:0] LV2 = 2'd2;
  localparam logic [1:0] LV3 = 2'd3;

  function automatic logic [1:0] com_level(logic addr, logic half, logic third);
    if (addr)  return half ? LV0 : LV3;
    if (third) return half ? LV2 : LV1;
    return LV1;
  endfunction

  function automatic logic [1:0] seg_level(logic lit, logic half, logic third, logic stat);
    if (lit)   return half ? LV3 : LV0;
    if (stat)  return half ? LV0 : LV3;
    if (third) return half ? LV1 : LV2;
    return LV1;
  endfunction
endpackage

// File: rtl/lcd_data_bank.sv
module lcd_data_bank #(
  parameter int GROUP_BYTES = 5,
  parameter int NUM_COM     = 4,
  localparam int NUM_SEG    = GROUP_BYTES * 8,
  localparam int NUM_BYTES  = GROUP_BYTES * NUM_COM,
  localparam int ADDR_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int COM_W      = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic               latch_i,
  input  logic [COM_W-1:0]   sel_com_i,
  output logic [NUM_SEG-1:0] seg_bits_o
);
  logic [NUM_BYTES*8-1:0] bank_q;
  logic [NUM_BYTES*8-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
    end else if (wr_en_i && (32'(wr_addr_i) < NUM_BYTES)) begin
      bank_q[32'(wr_addr_i)*8 +: 8] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shadow_q <= '0;
    else if (latch_i) shadow_q <= bank_q;
  end

  always_comb begin
    seg_bits_o = '0;
    if (32'(sel_com_i) < NUM_COM) seg_bits_o = shadow_q[32'(sel_com_i)*NUM_SEG +: NUM_SEG];
  end

  p_shadow_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(shadow_q));
endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl #(
  parameter int NUM_COM = 4,
  localparam int COM_W  = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             supply_ok_i,
  input  logic             slot_tick_i,
  input  logic [COM_W-1:0] duty_i,
  output logic             active_o,
  output logic [COM_W-1:0] com_o,
  output logic             half_o,
  output logic             latch_o,
  output logic             bound_o
);
  logic             active_q, half_q;
  logic [COM_W-1:0] com_q;
  logic             last_com;

  assign last_com = (com_q >= duty_i) || (32'(com_q) >= NUM_COM - 1);
  assign latch_o  = supply_ok_i && (!active_q || (slot_tick_i && half_q && last_com));
  assign bound_o  = supply_ok_i && (!active_q || slot_tick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0; com_q <= '0; half_q <= 1'b0;
    end else if (!supply_ok_i) begin
      active_q <= 1'b0; com_q <= '0; half_q <= 1'b0;
    end else if (!active_q) begin
      active_q <= 1'b1; com_q <= '0; half_q <= 1'b0;
    end else if (slot_tick_i) begin
      half_q <= !half_q;
      if (half_q) com_q <= last_com ? '0 : com_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign com_o    = com_q;
  assign half_o   = half_q;

  p_idle_home_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (!active_q && com_q == '0 && !half_q));
  p_half_flip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && supply_ok_i && slot_tick_i) |=> (half_q != $past(half_q)));
  p_frame_home_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> (active_q && com_q == '0 && !half_q));
endmodule

// File: rtl/lcd_drive_timer.sv
module lcd_drive_timer #(
  parameter int CNT_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [2:0] code_i,
  output logic       drive_on_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   limit;

  assign limit      = (CNT_W+1)'(2) << code_i;
  assign drive_on_o = (code_i == 3'd7) || ({1'b0, cnt_q} < limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (!(&cnt_q))       cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_mono_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
  import lcd_pkg::*;
#(
  parameter int GROUP_BYTES = 5,
  parameter int NUM_COM     = 4,
  localparam int NUM_SEG    = GROUP_BYTES * 8,
  localparam int NUM_BYTES  = GROUP_BYTES * NUM_COM,
  localparam int ADDR_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int COM_W      = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [7:0]           wr_data_i,
  input  logic [COM_W-1:0]     duty_i,
  input  logic                 bias_third_i,
  input  logic [2:0]           drive_code_i,
  input  logic                 supply_ok_i,
  input  logic                 slot_tick_i,
  output logic [2*NUM_COM-1:0] com_lvl_o,
  output logic [NUM_COM-1:0]   com_hiz_o,
  output logic [2*NUM_SEG-1:0] seg_lvl_o,
  output logic [NUM_SEG-1:0]   seg_hiz_o,
  output logic                 buf_en_o
);
  logic             active, half, latch, bound, drive_on;
  logic [COM_W-1:0] com;
  logic [NUM_SEG-1:0] seg_bits;
  logic             is_static, pins_on;

  lcd_seq_ctrl #(.NUM_COM(NUM_COM)) u_ctrl (
    .clk_i, .rst_ni, .supply_ok_i, .slot_tick_i, .duty_i,
    .active_o(active), .com_o(com), .half_o(half), .latch_o(latch), .bound_o(bound)
  );

  lcd_data_bank #(.GROUP_BYTES(GROUP_BYTES), .NUM_COM(NUM_COM)) u_bank (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .latch_i(latch), .sel_com_i(com), .seg_bits_o(seg_bits)
  );

  lcd_drive_timer #(.CNT_W(8)) u_timer (
    .clk_i, .rst_ni, .restart_i(bound), .code_i(drive_code_i), .drive_on_o(drive_on)
  );

  assign is_static = (duty_i == '0);
  assign pins_on   = active && (is_static || drive_on);
  assign buf_en_o  = active && !is_static && drive_on;

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    logic used;
    assign used = (COM_W'(c) <= duty_i);
    assign com_lvl_o[2*c +: 2] = (active && used) ?
        com_level(com == COM_W'(c), half, bias_third_i) : LV0;
    assign com_hiz_o[c] = !(pins_on && used);
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign seg_lvl_o[2*s +: 2] = active ?
        seg_level(seg_bits[s], half, bias_third_i, is_static) : LV0;
    assign seg_hiz_o[s] = !pins_on;
  end

  p_inhibit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (&seg_hiz_o && &com_hiz_o && !buf_en_o));
  p_static_nobuf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_static |-> !buf_en_o);
  p_drive_after_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound |=> drive_on);
endmodule

// File: tb/test_lcd_mux_seq.sv
module test_lcd_mux_seq;
  localparam int GB = 2, NC = 4, NS = GB * 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [2:0] wr_addr = '0; logic [7:0] wr_data = '0;
  logic [1:0] duty = 2'd3; logic third = 1; logic [2:0] code = 3'd7;
  logic supply = 0, tick = 0;
  logic [2*NC-1:0] com_lvl; logic [NC-1:0] com_hiz;
  logic [2*NS-1:0] seg_lvl; logic [NS-1:0] seg_hiz; logic buf_en;
  int checks = 0, errors = 0;
  logic [7:0] mem [8];

  always #4 clk = ~clk;

  lcd_mux_seq #(.GROUP_BYTES(GB), .NUM_COM(NC)) i_lcd_mux_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .duty_i(duty), .bias_third_i(third), .drive_code_i(code), .supply_ok_i(supply),
    .slot_tick_i(tick), .com_lvl_o(com_lvl), .com_hiz_o(com_hiz), .seg_lvl_o(seg_lvl),
    .seg_hiz_o(seg_hiz), .buf_en_o(buf_en));

  typedef struct packed {
    logic [1:0] duty; logic third; logic [3:0] steps; logic [7:0] com;
    logic [3:0] hiz; logic [1:0] lit; logic [1:0] dark; logic [1:0] dcom;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{2'd3, 1'b1, 4'd0, 8'h57, 4'h0, 2'd0, 2'd2, 2'd0},
    '{2'd3, 1'b1, 4'd1, 8'hA8, 4'h0, 2'd3, 2'd1, 2'd0},
    '{2'd3, 1'b1, 4'd2, 8'h5D, 4'h0, 2'd0, 2'd2, 2'd1},
    '{2'd3, 1'b1, 4'd5, 8'h8A, 4'h0, 2'd3, 2'd1, 2'd2},
    '{2'd3, 1'b1, 4'd6, 8'hD5, 4'h0, 2'd0, 2'd2, 2'd3},
    '{2'd3, 1'b1, 4'd8, 8'h57, 4'h0, 2'd0, 2'd2, 2'd0},
    '{2'd3, 1'b0, 4'd0, 8'h57, 4'h0, 2'd0, 2'd1, 2'd0},
    '{2'd3, 1'b0, 4'd3, 8'h51, 4'h0, 2'd3, 2'd1, 2'd1},
    '{2'd1, 1'b1, 4'd4, 8'h07, 4'hC, 2'd0, 2'd2, 2'd0},
    '{2'd1, 1'b1, 4'd3, 8'h02, 4'hC, 2'd3, 2'd1, 2'd1},
    '{2'd2, 1'b1, 4'd6, 8'h17, 4'h8, 2'd0, 2'd2, 2'd0},
    '{2'd0, 1'b1, 4'd0, 8'h03, 4'hE, 2'd0, 2'd3, 2'd0},
    '{2'd0, 1'b0, 4'd1, 8'h00, 4'hE, 2'd3, 2'd0, 2'd0},
    '{2'd0, 1'b1, 4'd2, 8'h03, 4'hE, 2'd0, 2'd3, 2'd0}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask
  task automatic step(); tick = 1; cyc(); tick = 0; endtask
  task automatic wr(int a, logic [7:0] d);
    wr_en = 1; wr_addr = 3'(a); wr_data = d; cyc(); wr_en = 0; mem[a] = d;
  endtask
  task automatic restart(logic [1:0] d, logic t);
    supply = 0; duty = d; third = t; cyc(); supply = 1; cyc();
  endtask

  function automatic logic [2*NS-1:0] seg_exp(int c, logic [1:0] lit, logic [1:0] dark);
    logic [2*NS-1:0] r;
    for (int s = 0; s < NS; s++) r[2*s +: 2] = mem[c*GB + s/8][s%8] ? lit : dark;
    return r;
  endfunction

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 reset com_hiz", 64'(com_hiz), 64'hF);
    chk("R1 reset seg_hiz", 64'(seg_hiz), 64'hFFFF);
    chk("R1 reset buf_en", 64'(buf_en), 64'h0);
    chk("R1 reset com_lvl", 64'(com_lvl), 64'h0);
    cyc(); rst_n = 1; cyc();
    wr(0, 8'hFF); wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'hFF);
    wr(4, 8'h0F); wr(5, 8'h0F); wr(6, 8'hAA); wr(7, 8'h55);
    step(); step(); step();
    chk("R1 inhibited seg_hiz", 64'(seg_hiz), 64'hFFFF);
    chk("R1 inhibited seg_lvl", 64'(seg_lvl), 64'h0);
    chk("R1 inhibited buf_en", 64'(buf_en), 64'h0);
    supply = 1; cyc();
    chk("R1 frame start com0", 64'(com_lvl), 64'h57);

    // stimulus table, drive code 7: pins stay driven
    for (int i = 0; i < 14; i++) begin
      vec_t v;
      string tg;
      v = VECS[i];
      code = 3'd7;
      restart(v.duty, v.third);
      for (int k = 0; k < int'(v.steps); k++) step();
      tg = (v.duty == 0) ? "R8" : (!v.third ? "R7" : "R5 R6");
      chk({"R2 ", tg, " com_lvl"}, 64'(com_lvl), 64'(v.com));
      chk({"R5 ", tg, " com_hiz"}, 64'(com_hiz), 64'(v.hiz));
      chk({"R3 ", tg, " seg_lvl"}, 64'(seg_lvl), 64'(seg_exp(int'(v.dcom), v.lit, v.dark)));
      chk({"R9 ", tg, " seg_hiz"}, 64'(seg_hiz), 64'h0);
      chk({"R9 ", tg, " buf_en"}, 64'(buf_en), 64'(v.duty != 0));
    end

    // R4: mid-frame write applies at the next frame only
    restart(2'd3, 1'b1);
    wr_en = 1; wr_addr = 3'd2; wr_data = 8'h3C; cyc(); wr_en = 0;
    step(); step();
    chk("R4 old data this frame", 64'(seg_lvl[15:0]), 64'hAAAA);
    repeat (8) step();
    chk("R4 new data next frame", 64'(seg_lvl[15:0]), 64'hA00A);
    chk("R3 upper byte of com1 group", 64'(seg_lvl[31:16]), 64'h0000);

    // R9 drive time
    code = 3'd0; restart(2'd3, 1'b1);
    chk("R9 code0 k0 buf_en", 64'(buf_en), 64'h1);
    cyc();
    chk("R9 code0 k1 seg_hiz", 64'(seg_hiz), 64'h0);
    cyc();
    chk("R9 code0 k2 buf_en", 64'(buf_en), 64'h0);
    chk("R9 code0 k2 seg_hiz", 64'(seg_hiz), 64'hFFFF);
    chk("R9 code0 k2 com_hiz", 64'(com_hiz), 64'hF);
    step();
    chk("R9 restart at boundary", 64'(buf_en), 64'h1);
    code = 3'd2; step();
    repeat (7) cyc();
    chk("R9 code2 k7 buf_en", 64'(buf_en), 64'h1);
    cyc();
    chk("R9 code2 k8 buf_en", 64'(buf_en), 64'h0);
    code = 3'd7; step();
    repeat (200) cyc();
    chk("R9 code7 whole phase", 64'(buf_en), 64'h1);
    chk("R9 code7 com_hiz", 64'(com_hiz), 64'h0);

    // R8 static ignores drive time
    code = 3'd0; restart(2'd0, 1'b1);
    repeat (10) cyc();
    chk("R8 static buf_en", 64'(buf_en), 64'h0);
    chk("R8 static seg_hiz", 64'(seg_hiz), 64'h0);
    chk("R8 static com0 driven", 64'(com_hiz), 64'hE);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule